// File: doc/BRIEF.md
# TIS Command Transmit Sequencer

This block is a hardware master that pushes one command into a TIS-style security device through a memory-mapped register port. The port offers one 32-bit status register and one byte-wide data FIFO register. A start strobe carries the command length. The sequencer fetches the command bytes one at a time from a local buffer with a one-cycle read latency. It waits for the device to report that it is ready. It then feeds bytes in bursts no larger than the burst count the device advertises, and checks the device's "expect more data" flag after every burst.

The final byte of the command is always held back and written on its own. Before that byte the expect flag must be set, and after it the flag must be clear. Only then does the sequencer start execution with a separate write of the go bit. Every wait on the status register is bounded by a poll budget, counted in clock cycles. The result is reported as a one-cycle done pulse, or as a one-cycle fail pulse with a held error code.

Top module: `tis_cmd_tx`

## Requirements
- R1: After an accepted start, the first register access is a status read, and no data byte is written until a status read has returned the ready bit (bit 6, 0x40) set. Status reads repeat while that bit is clear.
- R2: If the ready bit stays clear for POLL_BUDGET cycles, the sequencer raises fail with fail_code 1 (timeout) and writes nothing.
- R3: The burst count is status bits 23:8. Between two status reads, the sequencer writes at most min(burst, remaining - 1) data bytes, where burst is the value from the latest read.
- R4: While the burst count reads as zero, the sequencer keeps reading status and resumes writing once it is nonzero. If it stays zero for POLL_BUDGET cycles, it fails with fail_code 1.
- R5: After each burst, the sequencer polls until the valid bit (bit 7, 0x80) is set. If the expect bit (bit 3, 0x08) is then clear, it fails with fail_code 2 (overflow) and writes nothing further.
- R6: The last byte is written alone. It follows directly after a status read that shows valid, expect set and a nonzero burst count, and it is written only when exactly one byte remains.
- R7: After the last byte, the sequencer polls for valid. If expect is still set, it fails with fail_code 3 (unexpected status) and does not write the go word.
- R8: On success, the bytes go to the data register (reg_sel=1, reg_wide=0) in buffer order, starting at address 0. A status read after the last byte comes next. Then a single 32-bit write of 0x00000020 goes to the status register (reg_sel=0, reg_wide=1), followed by a one-cycle done pulse.
- R9: Only one register access is outstanding at a time. reg_req and its attributes stay stable until reg_ack.
- R10: A start with start_len zero is ignored, and so is a start while busy. In both cases no access is issued and no done or fail pulse occurs.
- R11: While in reset and directly after it, busy, reg_req, done, fail and buf_rd_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin sending a command (accepted only when idle) |
| start_len | input | LEN_W | Command length in bytes |
| buf_rd_en | output | 1 | Read strobe to the command buffer |
| buf_addr | output | ADDR_W | Byte address in the command buffer |
| buf_rdata | input | 8 | Buffer byte, valid the cycle after buf_rd_en |
| reg_req | output | 1 | Register access request, held until ack |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_sel | output | 1 | 0 = status register, 1 = data register |
| reg_wide | output | 1 | 1 = 32-bit word access, 0 = byte access |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Access complete; read data valid |
| reg_rdata | input | 32 | Read data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: command sent and go issued |
| fail | output | 1 | One-cycle pulse: command aborted |
| fail_code | output | 2 | 1 timeout, 2 overflow, 3 unexpected status; held until next start |

## Verification
The assertions rely on three properties of the environment. The device raises reg_ack only while reg_req is high. The buffer presents a byte exactly one cycle after buf_rd_en. start_len never exceeds MAX_LEN. The bench meets all three with a responder that acks only a request it has seen pending, after a programmable latency, and drops the ack one cycle later. The same responder loads buffer data on the falling edge of the strobe cycle, and every command length stays within the buffer. Device behaviour, covering ready delay, zero-burst stalls and an early or late expect flag, is scripted per vector so that each error path is entered through legal port activity.

// File: rtl/tis_tx_pkg.sv
package tis_tx_pkg;

  localparam int STAT_VALID_BIT  = 7;
  localparam int STAT_READY_BIT  = 6;
  localparam int STAT_GO_BIT     = 5;
  localparam int STAT_EXPECT_BIT = 3;
  localparam int BURST_LSB       = 8;
  localparam int BURST_W         = 16;
  localparam int WORD_W          = 32;

  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_DATA   = 1'b1;

  typedef enum logic [1:0] {
    FC_NONE       = 2'd0,
    FC_TIMEOUT    = 2'd1,
    FC_OVERFLOW   = 2'd2,
    FC_UNEXPECTED = 2'd3
  } fail_code_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_READY,
    ST_PLAN,
    ST_RD_BURST,
    ST_FETCH,
    ST_WR_DATA,
    ST_RD_VALID1,
    ST_FETCH_LAST,
    ST_WR_LAST,
    ST_RD_VALID2,
    ST_WR_GO
  } seq_state_e;

  typedef struct packed {
    logic              we;
    logic              sel;
    logic              wide;
    logic [WORD_W-1:0] wdata;
  } bus_cmd_t;

endpackage

// File: rtl/tx_poll_timer.sv
module tx_poll_timer #(
  parameter int BUDGET = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int CW = $clog2(BUDGET + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != CW'(BUDGET)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt == CW'(BUDGET));

  // R2 / R4: once the budget is spent it stays spent until the next wait begins
  a_r2_expire_holds: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);

endmodule

// File: rtl/tx_bus_master.sv
module tx_bus_master
  import tis_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  bus_cmd_t          cmd,
  output logic              cmp,
  output logic [WORD_W-1:0] rd_q,
  output logic              reg_req,
  output logic              reg_we,
  output logic              reg_sel,
  output logic              reg_wide,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic [WORD_W-1:0] reg_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_sel   <= SEL_STATUS;
      reg_wide  <= 1'b0;
      reg_wdata <= '0;
      cmp       <= 1'b0;
      rd_q      <= '0;
    end else begin
      cmp <= 1'b0;
      if (reg_req && reg_ack) begin
        reg_req <= 1'b0;
        cmp     <= 1'b1;
        rd_q    <= reg_rdata;
      end else if (issue && !reg_req) begin
        reg_req   <= 1'b1;
        reg_we    <= cmd.we;
        reg_sel   <= cmd.sel;
        reg_wide  <= cmd.wide;
        reg_wdata <= cmd.wdata;
      end
    end
  end

  // R9: a pending access keeps its attributes until acknowledged
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_sel)
                               && $stable(reg_wide) && $stable(reg_wdata)));

  // R9: the sequencer never asks for a second access while one is open
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    issue |-> !reg_req);

endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
  import tis_tx_pkg::*;
#(
  parameter int LEN_W  = 13,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              cmp,
  input  logic [WORD_W-1:0] rd_q,
  input  logic              expired,
  input  logic [7:0]        buf_rdata,
  output logic              issue,
  output bus_cmd_t          cmd,
  output logic              tmr_clr,
  output logic              buf_rd_en,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output fail_code_e        fail_code
);

  seq_state_e          state;
  logic                pend;
  logic [ADDR_W-1:0]   offset;
  logic [LEN_W-1:0]    remaining;
  logic [LEN_W-1:0]    chunk;
  logic [BURST_W-1:0]  burst;

  // status fields of the last completed read
  logic                st_valid, st_ready, st_expect;
  logic [BURST_W-1:0]  st_burst;
  logic                unused_rd;

  assign st_valid  = rd_q[STAT_VALID_BIT];
  assign st_ready  = rd_q[STAT_READY_BIT];
  assign st_expect = rd_q[STAT_EXPECT_BIT];
  assign st_burst  = rd_q[BURST_LSB +: BURST_W];
  assign unused_rd = ^{rd_q[WORD_W-1:BURST_LSB+BURST_W], rd_q[5:4], rd_q[2:0]};

  // bytes allowed in this burst: never the final one
  logic [31:0] burst_w32, rem_m1_w32, chunk_w32;
  assign burst_w32  = 32'(burst);
  assign rem_m1_w32 = 32'(remaining) - 32'd1;
  assign chunk_w32  = (burst_w32 < rem_m1_w32) ? burst_w32 : rem_m1_w32;

  logic bus_state;
  always_comb begin
    unique case (state)
      ST_RD_READY, ST_RD_BURST, ST_RD_VALID1, ST_RD_VALID2,
      ST_WR_DATA, ST_WR_LAST, ST_WR_GO: bus_state = 1'b1;
      default:                          bus_state = 1'b0;
    endcase
  end

  assign issue     = bus_state && !pend;
  assign buf_rd_en = (state == ST_FETCH) || (state == ST_FETCH_LAST);
  assign buf_addr  = offset;

  always_comb begin
    cmd = '{we: 1'b0, sel: SEL_STATUS, wide: 1'b1, wdata: '0};
    unique case (state)
      ST_WR_DATA, ST_WR_LAST: begin
        cmd.we    = 1'b1;
        cmd.sel   = SEL_DATA;
        cmd.wide  = 1'b0;
        cmd.wdata = {{(WORD_W-8){1'b0}}, buf_rdata};
      end
      ST_WR_GO: begin
        cmd.we    = 1'b1;
        cmd.wdata = WORD_W'(1) << STAT_GO_BIT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= 1'b0;
      offset    <= '0;
      remaining <= '0;
      chunk     <= '0;
      burst     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_code <= FC_NONE;
      tmr_clr   <= 1'b0;
    end else begin
      done    <= 1'b0;
      fail    <= 1'b0;
      tmr_clr <= 1'b0;
      if (issue) pend <= 1'b1;
      else if (cmp) pend <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (start && start_len != '0) begin
            offset    <= '0;
            remaining <= start_len;
            busy      <= 1'b1;
            fail_code <= FC_NONE;
            tmr_clr   <= 1'b1;
            state     <= ST_RD_READY;
          end
        end

        ST_RD_READY: if (cmp) begin
          if (st_ready) begin
            burst <= st_burst;
            state <= ST_PLAN;
          end else if (expired) begin
            fail <= 1'b1; fail_code <= FC_TIMEOUT; busy <= 1'b0; state <= ST_IDLE;
          end
        end

        ST_PLAN: begin
          if (burst == '0) begin
            tmr_clr <= 1'b1;
            state   <= ST_RD_BURST;
          end else begin
            chunk <= LEN_W'(chunk_w32);
            if (chunk_w32 == 32'd0) begin
              tmr_clr <= 1'b1;
              state   <= ST_RD_VALID1;
            end else begin
              state <= ST_FETCH;
            end
          end
        end

        ST_RD_BURST: if (cmp) begin
          if (st_burst != '0) begin
            burst <= st_burst;
            state <= ST_PLAN;
          end else if (expired) begin
            fail <= 1'b1; fail_code <= FC_TIMEOUT; busy <= 1'b0; state <= ST_IDLE;
          end
        end

        ST_FETCH: state <= ST_WR_DATA;

        ST_WR_DATA: if (cmp) begin
          offset    <= offset + 1'b1;
          remaining <= remaining - 1'b1;
          chunk     <= chunk - 1'b1;
          if (chunk == LEN_W'(1)) begin
            tmr_clr <= 1'b1;
            state   <= ST_RD_VALID1;
          end else begin
            state <= ST_FETCH;
          end
        end

        ST_RD_VALID1: if (cmp) begin
          if (st_valid) begin
            if (!st_expect) begin
              fail <= 1'b1; fail_code <= FC_OVERFLOW; busy <= 1'b0; state <= ST_IDLE;
            end else begin
              burst <= st_burst;
              if (remaining == LEN_W'(1) && st_burst != '0) state <= ST_FETCH_LAST;
              else                                          state <= ST_PLAN;
            end
          end else if (expired) begin
            fail <= 1'b1; fail_code <= FC_TIMEOUT; busy <= 1'b0; state <= ST_IDLE;
          end
        end

        ST_FETCH_LAST: state <= ST_WR_LAST;

        ST_WR_LAST: if (cmp) begin
          offset    <= offset + 1'b1;
          remaining <= remaining - 1'b1;
          tmr_clr   <= 1'b1;
          state     <= ST_RD_VALID2;
        end

        ST_RD_VALID2: if (cmp) begin
          if (st_valid) begin
            if (st_expect) begin
              fail <= 1'b1; fail_code <= FC_UNEXPECTED; busy <= 1'b0; state <= ST_IDLE;
            end else begin
              state <= ST_WR_GO;
            end
          end else if (expired) begin
            fail <= 1'b1; fail_code <= FC_TIMEOUT; busy <= 1'b0; state <= ST_IDLE;
          end
        end

        ST_WR_GO: if (cmp) begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3 / R6: a byte fetched inside the burst loop is never the final byte
  a_r3_hold_back_last: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |-> (chunk < remaining));

  // R6: the lone final byte is fetched only when exactly one byte is left
  a_r6_last_alone: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH_LAST) |-> (remaining == LEN_W'(1)));

  // R5 / R7: every abort carries a real error code
  a_r7_fail_has_code: assert property (@(posedge clk) disable iff (rst)
    fail |-> (fail_code != FC_NONE));

  // R8: success and failure are exclusive
  a_r8_done_fail_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  // R10: a zero-length start leaves the block idle
  a_r10_zero_len_ignored: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && start_len == '0) |=> !busy);

endmodule

// File: rtl/tis_cmd_tx.sv
module tis_cmd_tx
  import tis_tx_pkg::*;
#(
  parameter int MAX_LEN     = 4096,
  parameter int POLL_BUDGET = 100_000_000,
  localparam int LEN_W      = $clog2(MAX_LEN + 1),
  localparam int ADDR_W     = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  output logic              buf_rd_en,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic              reg_sel,
  output logic              reg_wide,
  output logic [31:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [31:0]       reg_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [1:0]        fail_code
);

  logic              issue, cmp, tmr_clr, expired;
  bus_cmd_t          cmd;
  logic [WORD_W-1:0] rd_q;
  fail_code_e        fc;

  tx_seq_fsm #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_len (start_len),
    .cmp       (cmp),
    .rd_q      (rd_q),
    .expired   (expired),
    .buf_rdata (buf_rdata),
    .issue     (issue),
    .cmd       (cmd),
    .tmr_clr   (tmr_clr),
    .buf_rd_en (buf_rd_en),
    .buf_addr  (buf_addr),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_code (fc)
  );

  tx_bus_master u_bus (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .cmd       (cmd),
    .cmp       (cmp),
    .rd_q      (rd_q),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wide  (reg_wide),
    .reg_wdata (reg_wdata),
    .reg_ack   (reg_ack),
    .reg_rdata (reg_rdata)
  );

  tx_poll_timer #(.BUDGET(POLL_BUDGET)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .expired (expired)
  );

  assign fail_code = fc;

  // R8: the only status write is the go word
  a_r8_go_word: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_we && reg_sel == SEL_STATUS) |-> (reg_wide && reg_wdata == 32'h0000_0020));

  // R8: data register traffic is byte-wide writes only
  a_r8_data_byte_write: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_sel == SEL_DATA) |-> (reg_we && !reg_wide && reg_wdata[31:8] == 24'h0));

  // R11: nothing is requested while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !reg_req);

endmodule

// File: tb/tis_cmd_tx_tb.sv
module tis_cmd_tx_tb;
  localparam int MAX_LEN = 64;
  localparam int BUDGET  = 60;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int ADDR_W  = $clog2(MAX_LEN);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  start_len = '0;
  logic              buf_rd_en;
  logic [ADDR_W-1:0] buf_addr;
  logic [7:0]        buf_rdata = '0;
  logic              reg_req, reg_we, reg_sel, reg_wide;
  logic [31:0]       reg_wdata;
  logic              reg_ack = 1'b0;
  logic [31:0]       reg_rdata = '0;
  logic              busy, done, fail;
  logic [1:0]        fail_code;

  always #5 clk = ~clk;

  tis_cmd_tx #(.MAX_LEN(MAX_LEN), .POLL_BUDGET(BUDGET)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_len(start_len),
    .buf_rd_en(buf_rd_en), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wide(reg_wide),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_code(fail_code)
  );

  typedef struct { logic sel; logic wide; logic [31:0] data; } exp_t;
  exp_t q[$];

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] mem [MAX_LEN];

  // device model configuration and state
  int cfg_ready_after, cfg_burst, cfg_zero_left, cfg_exp_len, cfg_lat, cmd_len;
  bit cfg_never_ready;
  int st_reads, rx, wsr, last_burst, lat_cnt;
  bit last_expect, ready_seen, read_after_last;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic service();
    exp_t e;
    if (!reg_we) begin
      bit rdy, exv;
      int b;
      st_reads++;
      rdy = !cfg_never_ready && (st_reads > cfg_ready_after);
      exv = (rx < cfg_exp_len);
      if (!rdy) b = 0;
      else if (cfg_zero_left > 0) begin b = 0; cfg_zero_left--; end
      else b = cfg_burst;
      reg_rdata = {8'h00, 16'(b), 1'b1, rdy, 1'b0, 1'b0, exv, 3'b000};
      wsr = 0; last_burst = b; last_expect = exv;
      if (rdy) ready_seen = 1;
      if (rx == cmd_len) read_after_last = 1;
    end else begin
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected write", {reg_sel, reg_wdata}, 0);
      end else begin
        e = q.pop_front();
        chk(reg_sel == e.sel && reg_wide == e.wide && reg_wdata == e.data, "R8",
            "write sel/width/data", {reg_sel, reg_wide, reg_wdata}, {e.sel, e.wide, e.data});
      end
      if (reg_sel) begin
        chk(ready_seen, "R1", "data before ready", 0, 1);
        chk(wsr < last_burst, "R3", "bytes beyond burst", wsr + 1, last_burst);
        if (rx == cmd_len - 1) begin
          chk(wsr == 0 && last_expect && last_burst != 0, "R6", "last byte not alone",
              {wsr[7:0], 7'd0, last_expect}, 1);
          read_after_last = 0;
        end
        rx++; wsr++;
      end else begin
        chk(read_after_last, "R8", "go without status read after last byte", 0, 1);
      end
    end
  endtask

  initial begin : responder
    forever begin
      @(negedge clk);
      if (buf_rd_en) buf_rdata = mem[buf_addr];
      if (reg_ack) reg_ack = 1'b0;
      else if (reg_req) begin
        if (lat_cnt < cfg_lat) lat_cnt++;
        else begin lat_cnt = 0; service(); reg_ack = 1'b1; end
      end
    end
  end

  task automatic finish_all();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_all();
  end

  task automatic run_cmd(int len, int ready_after, bit never_ready, int burst, int zero_reads,
                         int exp_delta, int lat, int n_bytes, bit want_go, int want_code,
                         bit extra_start, string tag, output int elapsed);
    int t0;
    bit got_done, got_fail;
    logic [1:0] code;
    cfg_ready_after = ready_after; cfg_never_ready = never_ready; cfg_burst = burst;
    cfg_zero_left = zero_reads; cfg_exp_len = len + exp_delta; cfg_lat = lat; cmd_len = len;
    st_reads = 0; rx = 0; wsr = 0; last_burst = 0; lat_cnt = 0;
    last_expect = 0; ready_seen = 0; read_after_last = 0;
    for (int i = 0; i < MAX_LEN; i++) mem[i] = 8'(i * 37 + len * 11 + 5);
    for (int i = 0; i < n_bytes; i++) q.push_back('{1'b1, 1'b0, {24'h0, mem[i]}});
    if (want_go) q.push_back('{1'b0, 1'b1, 32'h0000_0020});
    @(negedge clk);
    start = 1'b1; start_len = LEN_W'(len); t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (2) @(negedge clk);
      start = 1'b1; start_len = LEN_W'(2);
      @(negedge clk);
      start = 1'b0;
    end
    got_done = 0; got_fail = 0; code = '0;
    for (int k = 0; k < 5000 && !got_done && !got_fail; k++) begin
      @(negedge clk);
      got_done = done; got_fail = fail; code = fail_code;
    end
    elapsed = cyc - t0;
    if (want_code == 0)
      chk(got_done && !got_fail, tag, "completion by done", {got_fail, got_done}, 1);
    else
      chk(got_fail && !got_done && code == 2'(want_code), tag, "fail code",
          {got_fail, got_done, code}, {2'b10, 2'(want_code)});
    repeat (6) @(negedge clk);
    chk(q.size() == 0, tag, "writes missing or extra", q.size(), 0);
    chk(!busy && !reg_req, tag, "idle after result", {busy, reg_req}, 0);
    q.delete();
  endtask

  initial begin : main
    int el;
    // R11 reset state
    repeat (4) @(negedge clk);
    chk(!busy && !reg_req && !done && !fail && !buf_rd_en, "R11", "outputs in reset",
        {busy, reg_req, done, fail, buf_rd_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !reg_req && !done && !fail && !buf_rd_en, "R11", "outputs after reset",
        {busy, reg_req, done, fail, buf_rd_en}, 0);

    // R8 / R3: plain send, bursts of four
    run_cmd(10, 0, 0, 4, 0, 0, 0, 10, 1, 0, 0, "R8", el);
    // R6: single byte command goes straight to the lone final write
    run_cmd(1, 0, 0, 1, 0, 0, 0, 1, 1, 0, 0, "R6", el);
    // R1 / R10: ready arrives late, slow acks, a second start while busy
    run_cmd(7, 3, 0, 1, 0, 0, 2, 7, 1, 0, 1, "R1", el);
    // R4: burst stalls at zero, then resumes
    run_cmd(12, 0, 0, 3, 5, 0, 1, 12, 1, 0, 0, "R4", el);
    // R3: large burst, two-pass feed
    run_cmd(20, 1, 0, 16, 0, 0, 0, 20, 1, 0, 0, "R3", el);
    // R2: never ready
    run_cmd(5, 0, 1, 4, 0, 0, 0, 0, 0, 1, 0, "R2", el);
    chk(el >= BUDGET, "R2", "timeout before budget", el, BUDGET);
    // R4: burst stuck at zero forever
    run_cmd(5, 0, 0, 4, 1000, 0, 0, 0, 0, 1, 0, "R4", el);
    chk(el >= BUDGET, "R4", "stall timeout before budget", el, BUDGET);
    // R5: device stops expecting early
    run_cmd(8, 0, 0, 16, 0, -3, 0, 7, 0, 2, 0, "R5", el);
    // R7: device still expects after the last byte
    run_cmd(6, 0, 0, 16, 0, 3, 0, 6, 0, 3, 0, "R7", el);

    // R10: zero-length start is ignored
    @(negedge clk);
    start = 1'b1; start_len = '0;
    @(negedge clk);
    start = 1'b0;
    begin
      bit seen = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (busy || reg_req || done || fail) seen = 1;
      end
      chk(!seen, "R10", "activity after zero-length start", seen, 0);
    end

    // R8: a clean send after all error cases still succeeds
    run_cmd(3, 0, 0, 2, 0, 0, 3, 3, 1, 0, 0, "R8", el);

    finish_all();
  end

endmodule